// File: doc/BRIEF.md
# Framed Five-Wire Serial Port

This block is the device end of a five-wire serial link: a serial clock, a receive-frame sync, a transmit-frame sync, a data-out line and a data-in line. The converter supplies each new 10-bit result through a valid/ready stream input, and the port keeps that value in a holding register. A host reads that value out, most significant bit first. In the same frame, the host shifts a 10-bit control word in. The port only shifts and stores data, so reads work even while the converter core is powered down.

A bit counter limits each frame to ten serial clocks. A rising edge on the receive sync or a falling edge on the transmit sync re-arms the counter. When it re-arms, the output shift register takes a snapshot of the holding register. After that snapshot, a result that arrives during the frame cannot disturb the frame. A read that starts before a conversion ends therefore returns the previous result. The system clock samples all serial pins through two-flop synchronizers and runs at least four times faster than the serial clock. The serial clock may run freely or come in bursts.

The result stream has no back-pressure. `res_ready` stays high, and every cycle with `res_valid` high replaces the held value.

Top module: `framed_serial_port`

## Requirements
- R1: A cycle with `res_valid` high stores `res_data` in the holding register, and `res_ready` is always high. When `res_valid` is low, `res_data` is ignored.
- R2: A frame is armed by a rising edge on `rsync`, by a falling edge on `tsync`, or by both. Arming clears the bit count, even in the middle of a frame, and copies the holding register into the output shifter.
- R3: After arming, `sdo` stays low until the first rising edge of `sclk`. That edge enables the port.
- R4: Once the port is enabled, `sdo` presents the snapshot most significant bit first: bit 9 is presented before the first falling edge, and each falling edge of `sclk` advances one bit, down to bit 0.
- R5: Each enabled falling edge of `sclk` captures `sdi`. The first bit captured becomes bit 9 of the word. After the tenth bit, `ctrl_word` takes the assembled word and `ctrl_stb` is high for one system-clock cycle.
- R6: After ten bits, further `sclk` edges are ignored until the next arming edge. `ctrl_word` does not change, no strobe is issued, and `sdo` stays low.
- R7: A result accepted after arming does not appear in the current frame. It appears in the next frame.
- R8: While `rst_n` is low, `sdo`, `ctrl_word` and `ctrl_stb` are zero and the counter is in the finished state, so `sclk` edges are ignored until the first arming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| rsync | input | 1 | Receive-frame sync; rising edge arms a frame |
| tsync | input | 1 | Transmit-frame sync; falling edge arms a frame |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| res_valid | input | 1 | Result stream valid |
| res_data | input | 10 | Result stream data |
| res_ready | output | 1 | Result stream ready, always high |
| ctrl_word | output | 10 | Last complete control word received |
| ctrl_stb | output | 1 | One-cycle pulse when `ctrl_word` updates |

## Verification
The assertions check on every cycle that:
- the bit count never passes ten and stays at ten until the port is armed again;
- every arming edge clears the count and the enable;
- `sdo` is low whenever the port is not enabled;
- `ctrl_word` changes only together with a strobe, and a strobe is issued only when a frame completes.

Only the bench scenarios can show:
- the bit order on `sdo`;
- the assembly of the control word;
- isolation from a result that arrives mid-frame;
- that an aborted frame followed by a full one gives a clean word.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int unsigned FSP_DATA_W = 10;
  localparam int unsigned FSP_SYNC_STAGES = 2;
  // bit index of each pin inside the synchronizer vector
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_RSYNC = 1;
  localparam int unsigned PIN_TSYNC = 2;
  localparam int unsigned PIN_SDI = 3;
  localparam int unsigned PIN_COUNT = 4;
endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain   <= '0;
        prev[g] <= 1'b0;
      end else begin
        chain   <= {chain[STAGES-2:0], din[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign q[g] = chain[STAGES-1];
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/fsp_frame.sv
module fsp_frame #(
  parameter int unsigned DATA_W = 10,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] snap,
  output logic              sdo,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              ctrl_stb,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o
);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic              en;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= CNT_DONE;
      en       <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      ctrl_q   <= '0;
      ctrl_stb <= 1'b0;
    end else begin
      ctrl_stb <= 1'b0;
      if (arm) begin
        cnt   <= '0;
        en    <= 1'b0;
        tx_sr <= snap;
      end else if (cnt != CNT_DONE) begin
        if (sclk_rise && !en) en <= 1'b1;
        if (sclk_fall && en) begin
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          rx_sr <= {rx_sr[DATA_W-2:0], sdi_s};
          cnt   <= cnt + CNT_W'(1);
          if (cnt == CNT_LAST) begin
            ctrl_q   <= {rx_sr[DATA_W-2:0], sdi_s};
            ctrl_stb <= 1'b1;
            en       <= 1'b0;
          end
        end
      end
    end
  end

  assign sdo   = en & tx_sr[DATA_W-1];
  assign cnt_o = cnt;
  assign en_o  = en;
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W = FSP_DATA_W,
  parameter int unsigned SYNC_STAGES = FSP_SYNC_STAGES,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              rsync,
  input  logic              tsync,
  input  logic              sdi,
  output logic              sdo,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              res_ready,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              ctrl_stb
);
  logic [PIN_COUNT-1:0] pins, pin_q, pin_rise, pin_fall;
  logic [DATA_W-1:0]    hold;
  logic                 arm;
  logic [CNT_W-1:0]     cnt;
  logic                 en;

  assign pins[PIN_SCLK]  = sclk;
  assign pins[PIN_RSYNC] = rsync;
  assign pins[PIN_TSYNC] = tsync;
  assign pins[PIN_SDI]   = sdi;

  fsp_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  assign res_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) hold <= '0;
    else if (res_valid) hold <= res_data;
  end

  assign arm = pin_rise[PIN_RSYNC] | pin_fall[PIN_TSYNC];

  fsp_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .sclk_rise(pin_rise[PIN_SCLK]), .sclk_fall(pin_fall[PIN_SCLK]),
    .sdi_s(pin_q[PIN_SDI]), .snap(hold),
    .sdo(sdo), .ctrl_q(ctrl_word), .ctrl_stb(ctrl_stb),
    .cnt_o(cnt), .en_o(en)
  );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              sdo,
  input logic              ctrl_stb,
  input logic [DATA_W-1:0] ctrl_word
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DATA_W)); // R6
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DATA_W) && !arm) |=> cnt == CNT_W'(DATA_W)); // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cnt == '0 && !en)); // R2
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sdo); // R3
  AST_STB_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb |-> cnt == CNT_W'(DATA_W)); // R5
  AST_WORD_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> ctrl_stb); // R5
endmodule

bind framed_serial_port fsp_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsp_checker (
  .clk(clk), .rst_n(rst_n), .arm(arm), .cnt(cnt), .en(en),
  .sdo(sdo), .ctrl_stb(ctrl_stb), .ctrl_word(ctrl_word)
);

// File: tb/test_framed_serial_port.sv
module test_framed_serial_port;
  localparam int W = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, rsync = 1'b0, tsync = 1'b1, sdi = 1'b0;
  logic res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic sdo, res_ready, ctrl_stb;
  logic [W-1:0] ctrl_word;

  int checks = 0, errors = 0, stb_count = 0;

  always #2 clk = ~clk;

  framed_serial_port i_framed_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rsync(rsync), .tsync(tsync),
    .sdi(sdi), .sdo(sdo), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .ctrl_word(ctrl_word), .ctrl_stb(ctrl_stb)
  );

  always @(posedge clk) if (ctrl_stb) stb_count++;

  // {use tsync, result, control word}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 10'h2A5, 10'h15A},
    {1'b1, 10'h3FF, 10'h000},
    {1'b0, 10'h001, 10'h3FF},
    {1'b1, 10'h200, 10'h201},
    {1'b0, 10'h0F0, 10'h30C},
    {1'b1, 10'h1C7, 10'h0AA}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    #1;
  endtask

  task automatic load_result(input logic [W-1:0] v);
    @(negedge clk); res_valid = 1'b1; res_data = v;
    @(negedge clk); res_valid = 1'b0; res_data = ~v;
  endtask

  task automatic arm_frame(input bit use_t);
    @(negedge clk);
    if (use_t) tsync = 1'b0; else rsync = 1'b1;
    settle();
    @(negedge clk); tsync = 1'b1; rsync = 1'b0;
    settle();
  endtask

  task automatic pulses(input int n, input logic [W-1:0] ctl, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1; sdi = ctl[W-1-i];
      settle();
      got = {got[W-2:0], sdo};
      @(negedge clk); sclk = 1'b0;
      settle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] got, prev_word;
    int stb0;
    repeat (4) @(posedge clk);
    #1;
    // R8 reset state
    check(sdo == 1'b0, "R8 sdo in reset", sdo, 0);
    check(ctrl_word == '0, "R8 ctrl_word in reset", ctrl_word, 0);
    check(ctrl_stb == 1'b0, "R8 ctrl_stb in reset", ctrl_stb, 0);
    check(res_ready == 1'b1, "R1 res_ready high", res_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    settle();
    // R8 clocks before first arm are ignored
    pulses(3, 10'h3FF, got);
    check(stb_count == 0 && ctrl_word == '0, "R8 sclk ignored before arm", stb_count, 0);

    // vector table: R1 R2 R4 R5
    foreach (VEC[k]) begin
      stb0 = stb_count;
      load_result(VEC[k][19:10]);
      arm_frame(VEC[k][20]);
      pulses(W, VEC[k][9:0], got);
      check(got == VEC[k][19:10], "R4 sdo bits msb first", got, VEC[k][19:10]);
      check(ctrl_word == VEC[k][9:0], "R5 ctrl word", ctrl_word, VEC[k][9:0]);
      check(stb_count == stb0 + 1, "R5 single strobe", stb_count - stb0, 1);
    end

    // R6 extra clocks ignored
    prev_word = ctrl_word;
    stb0 = stb_count;
    pulses(3, ~prev_word, got);
    check(ctrl_word == prev_word, "R6 ctrl_word frozen", ctrl_word, prev_word);
    check(stb_count == stb0, "R6 no extra strobe", stb_count - stb0, 0);
    check(got == '0, "R6 sdo low after frame", got, 0);

    // R3 sdo low until first sclk rise; R1 ignored data without valid
    load_result(10'h3FF);
    @(negedge clk); res_data = 10'h000;
    arm_frame(1'b0);
    check(sdo == 1'b0, "R3 sdo low before enable", sdo, 0);
    pulses(W, 10'h155, got);
    check(got == 10'h3FF, "R1 held value without valid", got, 10'h3FF);

    // R7 result arriving mid-frame
    load_result(10'h0A3);
    arm_frame(1'b1);
    pulses(4, 10'h000, got);
    load_result(10'h35C);
    begin
      logic [W-1:0] tail;
      pulses(6, 10'h000, tail);
      got = {got[3:0], tail[5:0]};
    end
    check(got == 10'h0A3, "R7 frame keeps snapshot", got, 10'h0A3);
    arm_frame(1'b0);
    pulses(W, 10'h000, got);
    check(got == 10'h35C, "R7 next frame new result", got, 10'h35C);

    // R2 re-arm mid-frame restarts count
    load_result(10'h2C1);
    arm_frame(1'b0);
    pulses(5, 10'h3FF, got);
    stb0 = stb_count;
    arm_frame(1'b1);
    pulses(W, 10'h18E, got);
    check(got == 10'h2C1, "R2 re-armed frame data", got, 10'h2C1);
    check(ctrl_word == 10'h18E, "R2 re-armed ctrl word", ctrl_word, 10'h18E);
    check(stb_count == stb0 + 1, "R2 one strobe after re-arm", stb_count - stb0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule